// File: doc/BRIEF.md
# Successive-Approximation Result Formatter

This block sits between the successive-approximation core of a 12-bit converter and its parallel host bus. When a conversion starts it samples the two range-control bits: polarity and span. When the core finishes, it takes the raw comparator code and turns it into the output word the host reads. Unipolar ranges give straight binary. Bipolar ranges give two's complement, made from the core's offset-binary code by flipping the most significant bit. The range bits tied to the stored result are kept with it, so a control write made while a conversion is in progress cannot change how that result is coded.

Two fixed-point side outputs tell a host how to scale the stored result. The first is the full-scale multiplier applied to the reference voltage. The second is the weight of one code step. The output word is driven only while chip select and read are both low. At all other times the enable is low and the data lines are held at zero, which models the high-impedance bus.

Top module: `sar_result_formatter`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the stored result is 0, the stored range is polarity 0 / span 0, bus_oe is 0 and bus_data is 0.
- R2: With polarity bit range_sel[1] = 0 sampled at the conversion start, the stored word equals the raw code unchanged (straight binary).
- R3: With range_sel[1] = 1 sampled at the conversion start, the stored word is the raw code with bit 11 inverted. Raw 0x000 gives 0x800 (negative full scale), raw 0x800 gives 0x000 (zero) and raw 0xFFF gives 0x7FF (positive full scale less one step).
- R4: range_sel is sampled on the clock edge where conv_start is high. Later changes of range_sel do not affect the coding of the result stored by the next conv_done.
- R5: fs_mult, in unsigned Q4.12, is 5000 (about 1.2207) when the stored span bit range_sel[0] is 0 and 10000 (about 2.4414) when it is 1.
- R6: lsb_weight, in units of the reference voltage times 2^-24, equals fs_mult for a unipolar stored result and twice fs_mult for a bipolar one.
- R7: bus_oe is 1 exactly when cs_n and rd_n are both 0. While bus_oe is 0, bus_data is 0.
- R8: The stored word and its range change only on a clock edge with conv_done high. If conv_start and conv_done are high on the same edge, the result is coded with the range sampled by the earlier start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Conversion start pulse; samples range_sel |
| range_sel | input | 2 | {polarity, span}: bit 1 = bipolar, bit 0 = full span |
| conv_done | input | 1 | Conversion complete pulse; stores raw_code |
| raw_code | input | 12 | Raw successive-approximation code (offset binary) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_data | output | 12 | Formatted word, zero when not driven |
| bus_oe | output | 1 | Output enable for the tri-state bus |
| fs_mult | output | 16 | Full-scale multiplier of the stored range, Q4.12 |
| lsb_weight | output | 16 | Weight of one step, reference x 2^-24 |

## Verification
The bench uses bipolar codes at both ends and at mid-scale. A formatter that flips the wrong bit, or flips it in unipolar mode, returns 0x000 where 0x800 is expected, or returns a value that has lost its sign. It changes range_sel immediately after each start. A design that codes the result with the live range bits instead of the sampled ones then shows the wrong coding and the wrong multiplier. It asserts start and done on the same edge, which catches a register chain where the new range overtakes the pending result. It also raises only one of the two strobes at a time, because a gate that decodes just one of them would drive the bus when it should not.

// File: rtl/adc_fmt_pkg.sv
// Shared types for the result formatter.
package adc_fmt_pkg;
    // Range setting: polarity (bipolar when set) and span (full when set).
    typedef struct packed {
        logic bip;
        logic span;
    } range_t;
endpackage

// File: rtl/range_capture.sv
// Holds the range bits for a conversion in flight and for the stored result.
// Assumes conv_start and conv_done are single-cycle pulses. When both are
// high on one edge, the result takes the range sampled by the earlier start.
module range_capture
    import adc_fmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  range_t range_i,
    input  logic   done_i,
    output range_t pend_o,
    output range_t res_o
);
    range_t pend_q;
    range_t res_q;

    // Sample the range at conversion start; hand it to the result at done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            res_q  <= '0;
        end else begin
            if (start_i) pend_q <= range_i;
            if (done_i)  res_q  <= pend_q;
        end
    end

    assign pend_o = pend_q;
    assign res_o  = res_q;
endmodule

// File: rtl/code_map.sv
// Maps an offset-binary raw code to the output coding. Unipolar leaves the
// code as it is; bipolar inverts the top bit, giving two's complement.
module code_map #(
    parameter int CODE_W = 12
) (
    input  logic              bip_i,
    input  logic [CODE_W-1:0] raw_i,
    output logic [CODE_W-1:0] word_o
);
    // Inverting the MSB converts offset binary to two's complement.
    always_comb begin
        word_o            = raw_i;
        word_o[CODE_W-1]  = raw_i[CODE_W-1] ^ bip_i;
    end
endmodule

// File: rtl/scale_select.sv
// Returns the full-scale multiplier and the step weight for a range.
// The multiplier is in fixed point with MULT_FRAC fraction bits. The step
// weight is in units of reference / 2^(CODE_W + MULT_FRAC); the bipolar
// span is twice as wide, so its step is twice as large.
module scale_select
    import adc_fmt_pkg::*;
#(
    parameter int MULT_W    = 16,
    parameter int MULT_HALF = 5000,
    parameter int MULT_FULL = 10000
) (
    input  range_t             range_i,
    output logic [MULT_W-1:0]  mult_o,
    output logic [MULT_W-1:0]  lsb_o
);
    localparam logic [MULT_W-1:0] HALF_V = MULT_W'(MULT_HALF);
    localparam logic [MULT_W-1:0] FULL_V = MULT_W'(MULT_FULL);

    // Choose the multiplier by span, then double the step for bipolar.
    always_comb begin
        mult_o = range_i.span ? FULL_V : HALF_V;
        lsb_o  = range_i.bip ? {mult_o[MULT_W-2:0], 1'b0} : mult_o;
    end
endmodule

// File: rtl/read_gate.sv
// Enables the output bus only during a qualified read (select and read both
// low). The data lines are forced to zero when the bus is not driven.
module read_gate #(
    parameter int CODE_W = 12
) (
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic [CODE_W-1:0] word_i,
    output logic              oe_o,
    output logic [CODE_W-1:0] data_o
);
    // Both strobes low qualify a read.
    always_comb begin
        oe_o   = ~cs_n_i & ~rd_n_i;
        data_o = oe_o ? word_i : '0;
    end
endmodule

// File: rtl/sar_result_formatter.sv
// Top level: stores each finished conversion in the coding chosen by the
// range sampled at its start, reports the scale factors of the stored result
// and presents the word to the host bus during qualified reads.
module sar_result_formatter
    import adc_fmt_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int MULT_W    = 16,
    parameter int MULT_HALF = 5000,
    parameter int MULT_FULL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic [1:0]        range_sel,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic [CODE_W-1:0] bus_data,
    output logic              bus_oe,
    output logic [MULT_W-1:0] fs_mult,
    output logic [MULT_W-1:0] lsb_weight
);
    range_t              pend_range;
    range_t              res_range;
    logic [CODE_W-1:0]   fmt_word;
    logic [CODE_W-1:0]   result_q;

    range_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (conv_start),
        .range_i (range_t'(range_sel)),
        .done_i  (conv_done),
        .pend_o  (pend_range),
        .res_o   (res_range)
    );

    code_map #(.CODE_W(CODE_W)) u_map (
        .bip_i  (pend_range.bip),
        .raw_i  (raw_code),
        .word_o (fmt_word)
    );

    // Store the formatted word when the conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)         result_q <= '0;
        else if (conv_done) result_q <= fmt_word;
    end

    scale_select #(
        .MULT_W    (MULT_W),
        .MULT_HALF (MULT_HALF),
        .MULT_FULL (MULT_FULL)
    ) u_scale (
        .range_i (res_range),
        .mult_o  (fs_mult),
        .lsb_o   (lsb_weight)
    );

    read_gate #(.CODE_W(CODE_W)) u_gate (
        .cs_n_i (cs_n),
        .rd_n_i (rd_n),
        .word_i (result_q),
        .oe_o   (bus_oe),
        .data_o (bus_data)
    );
endmodule

// File: rtl/sar_result_formatter_chk.sv
// Checker for sar_result_formatter, attached with bind below.
module sar_result_formatter_chk #(
    parameter int CODE_W    = 12,
    parameter int MULT_W    = 16,
    parameter int MULT_HALF = 5000,
    parameter int MULT_FULL = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_start,
    input logic [1:0]        range_sel,
    input logic              conv_done,
    input logic [CODE_W-1:0] raw_code,
    input logic              cs_n,
    input logic              rd_n,
    input logic [CODE_W-1:0] bus_data,
    input logic              bus_oe,
    input logic [MULT_W-1:0] fs_mult,
    input logic [MULT_W-1:0] lsb_weight,
    input logic [1:0]        pend_bits,
    input logic [CODE_W-1:0] result_q
);
    p_start_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> pend_bits == $past(range_sel));

    p_unipolar_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !pend_bits[1]) |=> result_q == $past(raw_code));

    p_bipolar_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && pend_bits[1]) |=>
            (result_q[CODE_W-1] != $past(raw_code[CODE_W-1])) &&
            (result_q[CODE_W-2:0] == $past(raw_code[CODE_W-2:0])));

    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(result_q));

    p_mult_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_mult == MULT_W'(MULT_HALF)) || (fs_mult == MULT_W'(MULT_FULL)));

    p_step_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lsb_weight == fs_mult) || (lsb_weight == (fs_mult << 1)));

    p_read_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n) |-> (bus_oe && bus_data == result_q));

    p_bus_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!bus_oe && bus_data == '0));
endmodule

bind sar_result_formatter sar_result_formatter_chk #(
    .CODE_W    (CODE_W),
    .MULT_W    (MULT_W),
    .MULT_HALF (MULT_HALF),
    .MULT_FULL (MULT_FULL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .range_sel  (range_sel),
    .conv_done  (conv_done),
    .raw_code   (raw_code),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .bus_data   (bus_data),
    .bus_oe     (bus_oe),
    .fs_mult    (fs_mult),
    .lsb_weight (lsb_weight),
    .pend_bits  (pend_range),
    .result_q   (result_q)
);

// File: tb/sar_result_formatter_bench.sv
module sar_result_formatter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic [1:0]  range_sel = 2'b00;
    logic        conv_done = 1'b0;
    logic [11:0] raw_code = '0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [11:0] bus_data;
    logic        bus_oe;
    logic [15:0] fs_mult;
    logic [15:0] lsb_weight;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sar_result_formatter u_sar_result_formatter (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .range_sel(range_sel),
        .conv_done(conv_done), .raw_code(raw_code), .cs_n(cs_n), .rd_n(rd_n),
        .bus_data(bus_data), .bus_oe(bus_oe), .fs_mult(fs_mult), .lsb_weight(lsb_weight)
    );

    // {range, raw, expected word, expected multiplier, expected step}
    localparam logic [57:0] VEC [8] = '{
        {2'b00, 12'h000, 12'h000, 16'd5000,  16'd5000},
        {2'b00, 12'hFFF, 12'hFFF, 16'd5000,  16'd5000},
        {2'b01, 12'hABC, 12'hABC, 16'd10000, 16'd10000},
        {2'b10, 12'h000, 12'h800, 16'd5000,  16'd10000},
        {2'b10, 12'h800, 12'h000, 16'd5000,  16'd10000},
        {2'b11, 12'hFFF, 12'h7FF, 16'd10000, 16'd20000},
        {2'b11, 12'h7FF, 12'hFFF, 16'd10000, 16'd20000},
        {2'b11, 12'h123, 12'h923, 16'd10000, 16'd20000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Read the bus and check the word, the enable and the scale outputs.
    task automatic read_check(input string req, input logic [11:0] w,
                              input logic [15:0] m, input logic [15:0] l);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        check({req, " word"}, 32'(bus_data), 32'(w));
        check("R7 oe during read", 32'(bus_oe), 32'd1);
        check("R5 fs_mult", 32'(fs_mult), 32'(m));
        check("R6 lsb_weight", 32'(lsb_weight), 32'(l));
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // Start with range r, flip range_sel, then complete with raw.
    task automatic convert(input logic [1:0] r, input logic [11:0] raw);
        @(posedge clk); #1;
        conv_start = 1'b1; range_sel = r;
        @(posedge clk); #1;
        conv_start = 1'b0; range_sel = ~r;   // R4: late change must not matter
        conv_done = 1'b1; raw_code = raw;
        @(posedge clk); #1;
        conv_done = 1'b0; raw_code = ~raw;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        // R1 reset state
        check("R1 oe after reset", 32'(bus_oe), 32'd0);
        check("R1 data after reset", 32'(bus_data), 32'd0);
        check("R1 fs_mult after reset", 32'(fs_mult), 32'd5000);
        check("R1 lsb after reset", 32'(lsb_weight), 32'd5000);
        read_check("R1 stored word", 12'h000, 16'd5000, 16'd5000);

        // R2/R3/R4 vector table
        foreach (VEC[i]) begin
            convert(VEC[i][57:56], VEC[i][55:44]);
            read_check(VEC[i][57] ? "R3 R4 bipolar" : "R2 R4 unipolar",
                       VEC[i][43:32], VEC[i][31:16], VEC[i][15:0]);
        end

        // R7: one strobe alone does not drive the bus
        cs_n = 1'b0; rd_n = 1'b1; #1;
        check("R7 cs only oe", 32'(bus_oe), 32'd0);
        check("R7 cs only data", 32'(bus_data), 32'd0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        check("R7 rd only oe", 32'(bus_oe), 32'd0);
        check("R7 rd only data", 32'(bus_data), 32'd0);
        rd_n = 1'b1;

        // R8: no done, word held despite raw and range changes
        @(posedge clk); #1; raw_code = 12'h555; range_sel = 2'b00;
        @(posedge clk); #1;
        @(posedge clk); #1;
        read_check("R8 hold", 12'h923, 16'd10000, 16'd20000);

        // R8: start and done together use the earlier range
        @(posedge clk); #1; conv_start = 1'b1; range_sel = 2'b00;
        @(posedge clk); #1; conv_start = 1'b1; range_sel = 2'b11;
        conv_done = 1'b1; raw_code = 12'h800;
        @(posedge clk); #1; conv_start = 1'b0; range_sel = 2'b00;
        read_check("R8 same-edge old range", 12'h800, 16'd5000, 16'd5000);
        raw_code = 12'h800;
        @(posedge clk); #1; conv_done = 1'b0;
        read_check("R8 next done new range", 12'h000, 16'd10000, 16'd20000);

        // R1: reset again clears the stored state
        rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        read_check("R1 word after second reset", 12'h000, 16'd5000, 16'd5000);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule